// File: doc/BRIEF.md
# I2C Byte Master With Command Registers

This block is an I2C bus master that a processor drives one byte at a time through two registers. The control/status register holds three request bits: start, stop and final-read. It also holds three read-only flags: done, acknowledge and bus error. The data register holds the byte to send or the byte last received. START and STOP appear on the bus only when their request bits ask for them. Between conditions the master keeps SCL low and waits for the next byte command.

Writing the data register queues a byte write. Reading the data register returns the last received byte and, while the bus is owned, queues the next byte read. The bus is owned from the end of a START until the end of a STOP. A queued byte waits until the bus is owned and no START is pending. Each quarter of an SCL period lasts `QDIV` system clocks. Both bus lines are open-drain: a drive-low enable per line plus a sampled input per line, passed through a synchroniser.

Top module: `i2c_byte_master`

Register map, with `cpu_addr` 0 for control/status and 1 for data. The control/status bits are:
- bit 0: start request
- bit 1: stop request
- bit 2: final-read
- bit 4: done
- bit 5: acknowledge
- bit 6: bus error

Bits 3 and 7 read as zero. Writing the control register loads bits 0 to 2.

## Requirements
- R1: After reset both drive enables are low (bus released) and the control/status register reads 0x00.
- R2: A START (SDA falling while SCL is high) is made only after the start request bit is set, and that bit reads 0 once the START is complete.
- R3: A written byte goes out most significant bit first, one bit per SCL pulse; SDA changes only while SCL is low.
- R4: On the ninth SCL pulse of a write, SDA is released and sampled; when done rises the acknowledge flag holds the inverse of that sample (1 = slave acknowledged).
- R5: During a read the master releases SDA for eight SCL pulses, drives SDA low on the ninth, and the received byte (MSB first) is returned by the next data-register read.
- R6: With final-read set, the ninth pulse of the read is left released (not-acknowledge) and final-read reads 0 once that byte is done.
- R7: A STOP (SDA rising while SCL is high) is made only after the stop request bit is set and that bit then reads 0; a final-read alone leaves SCL held low and makes no STOP.
- R8: Any data-register read or write clears done and bus error; a data read starts a byte read only while the bus is owned, so a read after a STOP causes no bus activity.
- R9: Bus error sets when SDA is sampled low while the master expects it released (a written 1, a not-acknowledge or a START setup), or when SCL is seen low at the end of its high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (data register read has side effects) |
| cpu_addr | input | 1 | 0 = control/status, 1 = data |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from the addressed register |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
On every cycle the assertions check the following. During a byte, SDA moves only while SCL is low. Any SDA fall with SCL high comes from the START sequence, and any SDA rise with SCL high comes from the STOP sequence. Read data bits keep SDA released. Done rises only at a byte's end, and final-read clears by itself only there. Bus error rises only while a bus sequence is running. Other behaviours show only in the bench's scenarios, where a bus model acknowledges, supplies read bytes or jams SDA. These are the bit order and values on the wire, the acknowledge flag against the slave's answer, the received byte returned, a held bus without STOP after a final read, and no activity after a data read once the bus is free.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BIT   = 2'd2,
        ST_STOP  = 2'd3
    } seq_e;

    localparam int CB_START = 0;
    localparam int CB_STOP  = 1;
    localparam int CB_LAST  = 2;
    localparam int CB_DONE  = 4;
    localparam int CB_ACK   = 5;
    localparam int CB_BERR  = 6;
    localparam int BYTE_W   = 8;

    typedef struct packed {
        seq_e              st;
        logic [1:0]        ph;
        logic [3:0]        bitn;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] dat;
        logic              samp;
        logic              rd;
        logic              scl_oe;
        logic              sda_oe;
        logic              req_start;
        logic              req_stop;
        logic              last_rd;
        logic              done;
        logic              ack;
        logic              berr;
        logic              pend;
        logic              pend_rd;
        logic              owned;
    } core_t;

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
    parameter int QDIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(QDIV - 1)) && !clr;
        cnt_d = cnt_q + CW'(1);
        if (clr || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] s_d, s_q;

    always_comb begin
        s_d[0] = d;
        for (int i = 1; i < STAGES; i++) s_d[i] = s_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign q = s_q[STAGES-1];
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int QDIV        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic       cpu_addr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

    core_t c_d, c_q;
    logic  tick, scl_s, sda_s;

    i2cm_qtick #(.QDIV(QDIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (c_q.st == ST_IDLE),
        .tick (tick)
    );

    i2cm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_in, sda_in}),
        .q    ({scl_s, sda_s})
    );

    always_comb begin
        c_d = c_q;

        // processor side
        if (cpu_wr && !cpu_addr) begin
            c_d.req_start = cpu_wdata[CB_START];
            c_d.req_stop  = cpu_wdata[CB_STOP];
            c_d.last_rd   = cpu_wdata[CB_LAST];
        end
        if (cpu_wr && cpu_addr) begin
            c_d.sh      = cpu_wdata;
            c_d.pend    = 1'b1;
            c_d.pend_rd = 1'b0;
            c_d.done    = 1'b0;
            c_d.berr    = 1'b0;
        end
        if (cpu_rd && cpu_addr) begin
            c_d.done = 1'b0;
            c_d.berr = 1'b0;
            if (c_q.owned) begin
                c_d.pend    = 1'b1;
                c_d.pend_rd = 1'b1;
            end
        end

        // bus sequencer: four quarters per SCL period
        if (c_q.st == ST_IDLE) begin
            if (c_q.req_start) begin
                c_d.st = ST_START; c_d.ph = 2'd0; c_d.scl_oe = 1'b1;
            end else if (c_q.pend && c_q.owned) begin
                c_d.st = ST_BIT;   c_d.ph = 2'd0; c_d.scl_oe = 1'b1;
                c_d.bitn = 4'd0;   c_d.rd = c_q.pend_rd; c_d.pend = 1'b0;
            end else if (c_q.req_stop) begin
                c_d.st = ST_STOP;  c_d.ph = 2'd0; c_d.scl_oe = 1'b1;
            end
        end else if (tick) begin
            c_d.ph = c_q.ph + 2'd1;
            case (c_q.ph)
                2'd0: begin
                    unique case (c_q.st)
                        ST_START: c_d.sda_oe = 1'b0;
                        ST_STOP:  c_d.sda_oe = 1'b1;
                        default:  c_d.sda_oe = c_q.rd
                                  ? (c_q.bitn == ACK_SLOT && !c_q.last_rd)
                                  : (c_q.bitn != ACK_SLOT && !c_q.sh[BYTE_W-1]);
                    endcase
                end
                2'd1: c_d.scl_oe = 1'b0;
                2'd2: begin
                    c_d.samp = sda_s;
                    if (c_q.st == ST_START) begin
                        if (!sda_s) c_d.berr = 1'b1;
                        c_d.sda_oe = 1'b1;
                    end else if (c_q.st == ST_STOP) begin
                        c_d.sda_oe = 1'b0;
                    end else if (!sda_s && !c_q.sda_oe &&
                                 (c_q.rd ? (c_q.bitn == ACK_SLOT) : (c_q.bitn != ACK_SLOT))) begin
                        c_d.berr = 1'b1;
                    end
                end
                default: begin
                    if (!scl_s) c_d.berr = 1'b1;
                    unique case (c_q.st)
                        ST_START: begin
                            c_d.st = ST_IDLE; c_d.req_start = 1'b0; c_d.owned = 1'b1;
                        end
                        ST_STOP: begin
                            c_d.st = ST_IDLE; c_d.req_stop = 1'b0; c_d.owned = 1'b0;
                        end
                        default: begin
                            c_d.scl_oe = 1'b1;
                            if (c_q.bitn == ACK_SLOT) begin
                                c_d.st   = ST_IDLE;
                                c_d.done = 1'b1;
                                if (c_q.rd) begin
                                    c_d.dat     = c_q.sh;
                                    c_d.last_rd = 1'b0;
                                end else begin
                                    c_d.ack = !c_q.samp;
                                end
                            end else begin
                                c_d.sh   = {c_q.sh[BYTE_W-2:0], c_q.samp};
                                c_d.bitn = c_q.bitn + 4'd1;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign scl_oe    = c_q.scl_oe;
    assign sda_oe    = c_q.sda_oe;
    assign cpu_rdata = cpu_addr ? c_q.dat
                     : {1'b0, c_q.berr, c_q.ack, c_q.done, 1'b0,
                        c_q.last_rd, c_q.req_stop, c_q.req_start};

    // R3: SDA never moves inside a byte while SCL is released
    p_sda_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_BIT && !$stable(c_q.sda_oe)) |-> c_q.scl_oe);

    // R2: SDA falling with SCL high only comes from the START sequence
    p_start_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(c_q.sda_oe) && !c_q.scl_oe) |-> $past(c_q.st) == ST_START);

    // R7: SDA rising with SCL high only comes from the STOP sequence
    p_stop_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(c_q.sda_oe) && !c_q.scl_oe) |-> $past(c_q.st) == ST_STOP);

    // R5: data bits of a read keep SDA released while SCL is high
    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_BIT && c_q.rd && c_q.bitn != ACK_SLOT && c_q.ph[1]) |-> !c_q.sda_oe);

    // R4: done only rises at the end of a byte
    p_done_from_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.done) |-> $past(c_q.st) == ST_BIT);

    // R6: final-read clears on its own only at the end of a byte
    p_lastrd_self_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(c_q.last_rd) && !$past(cpu_wr && !cpu_addr)) |-> ($past(c_q.st) == ST_BIT && c_q.done));

    // R9: bus error rises only while a bus sequence runs
    p_berr_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.berr) |-> $past(c_q.st) != ST_IDLE);
endmodule

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
    localparam int QD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_addr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       scl_oe, sda_oe, slv_low;

    wire scl_ln = !scl_oe;
    wire sda_ln = !(sda_oe || slv_low);

    always #2.5 clk = !clk;

    i2c_byte_master #(.QDIV(QD)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .scl_in(scl_ln), .sda_in(sda_ln), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int nchk = 0, nerr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bus model: 0 none, 1 write acceptor, 2 read source, 3 jammer
    int       role = 0;
    bit       ack_en = 1'b1;
    bit [7:0] rbyte = '0;
    bit       framed = 1'b0, rd_quit = 1'b0;
    int       slot = -1;

    always_comb begin
        slv_low = 1'b0;
        if (framed && slot >= 0) begin
            if (role == 1) slv_low = (slot == 8) && ack_en;
            if (role == 2) slv_low = (slot < 8) && !rd_quit && !rbyte[7 - slot];
            if (role == 3) slv_low = (slot < 8);
        end
    end

    // scoreboard: kind 1 START, 2 STOP, 3 byte
    typedef struct { int kind; bit [7:0] val; bit nack; string req; } item_t;
    item_t expq[$];

    task automatic expect_item(input int kind, input bit [7:0] val, input bit nack, input string req);
        item_t it;
        it.kind = kind; it.val = val; it.nack = nack; it.req = req;
        expq.push_back(it);
    endtask

    task automatic observe(input int kind, input bit [7:0] val, input bit nack);
        item_t it;
        if (expq.size() == 0) begin
            chk(1'b0, "R8", "unexpected bus event", kind, 0);
        end else begin
            it = expq.pop_front();
            chk(it.kind == kind, it.req, "bus event kind", kind, it.kind);
            if (kind == 3) begin
                chk(val == it.val, it.req, "byte on wire", val, it.val);
                chk(nack == it.nack, it.req, "ninth-bit level", nack, it.nack);
            end
        end
    endtask

    bit       p_scl = 1'b1, p_sda = 1'b1;
    bit [7:0] mon_sh = '0;

    always @(scl_ln, sda_ln) begin
        if (rst_n) begin
            if (scl_ln && p_scl && p_sda && !sda_ln) begin
                framed = 1'b1; slot = -1; rd_quit = 1'b0;
                observe(1, 8'h00, 1'b0);
            end else if (scl_ln && p_scl && !p_sda && sda_ln) begin
                framed = 1'b0;
                observe(2, 8'h00, 1'b0);
            end else if (!scl_ln && p_scl) begin
                if (framed) slot = (slot + 1) % 9;
            end else if (scl_ln && !p_scl && framed && slot >= 0) begin
                if (slot < 8) mon_sh = {mon_sh[6:0], sda_ln};
                else begin
                    if (role == 2 && sda_ln) rd_quit = 1'b1;
                    observe(3, mon_sh, sda_ln);
                end
            end
        end
        p_scl = scl_ln;
        p_sda = sda_ln;
    end

    task automatic cpu_write(input bit a, input bit [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input bit a, output bit [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic wait_done(output bit [7:0] st);
        for (int i = 0; i < 3000; i++) begin
            cpu_read(1'b0, st);
            if (st[4]) break;
        end
    endtask

    task automatic wait_stop(output bit [7:0] st);
        for (int i = 0; i < 3000; i++) begin
            cpu_read(1'b0, st);
            if (!st[1]) break;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        bit [7:0] st, d;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "drive enables", {scl_oe, sda_oe}, 0);
        cpu_read(1'b0, st);
        chk(st == 8'h00, "R1", "status after reset", st, 0);

        // R2/R3/R4: START, then write A6 acknowledged
        role = 1; ack_en = 1'b1;
        expect_item(1, 0, 0, "R2");
        expect_item(3, 8'hA6, 1'b0, "R3");
        cpu_write(1'b0, 8'h01);
        cpu_write(1'b1, 8'hA6);
        wait_done(st);
        chk(st[4] == 1'b1, "R4", "done after write", st[4], 1);
        chk(st[5] == 1'b1, "R4", "ack flag with slave ack", st[5], 1);
        chk(st[0] == 1'b0, "R2", "start request cleared", st[0], 0);

        // R8 done cleared by data write; R4 not-acknowledged; R9 no error on all-zero byte
        ack_en = 1'b0;
        expect_item(3, 8'h00, 1'b1, "R4");
        cpu_write(1'b1, 8'h00);
        cpu_read(1'b0, st);
        chk(st[4] == 1'b0, "R8", "done cleared by data write", st[4], 0);
        wait_done(st);
        chk(st[5] == 1'b0, "R4", "ack flag with slave nack", st[5], 0);
        chk(st[6] == 1'b0, "R9", "no bus error on driven zeros", st[6], 0);

        // repeated START, address byte, then two reads
        ack_en = 1'b1;
        expect_item(1, 0, 0, "R2");
        expect_item(3, 8'h5B, 1'b0, "R3");
        cpu_write(1'b0, 8'h01);
        cpu_write(1'b1, 8'h5B);
        wait_done(st);
        chk(st[5] == 1'b1, "R4", "address acknowledged", st[5], 1);

        role = 2; rbyte = 8'h96;
        expect_item(3, 8'h96, 1'b0, "R5");
        cpu_read(1'b1, d);
        wait_done(st);
        chk(st[2] == 1'b0, "R6", "final-read idle during normal read", st[2], 0);

        cpu_write(1'b0, 8'h04);
        rbyte = 8'h3D;
        expect_item(3, 8'h3D, 1'b1, "R6");
        cpu_read(1'b1, d);
        chk(d == 8'h96, "R5", "first received byte", d, 8'h96);
        wait_done(st);
        chk(st[2] == 1'b0, "R6", "final-read self-cleared", st[2], 0);
        repeat (40) @(negedge clk);
        chk(scl_oe == 1'b1, "R7", "SCL held low without STOP", scl_oe, 1);

        expect_item(2, 0, 0, "R7");
        cpu_write(1'b0, 8'h02);
        wait_stop(st);
        chk(st[1] == 1'b0, "R7", "stop request cleared", st[1], 0);
        cpu_read(1'b1, d);
        chk(d == 8'h3D, "R5", "final received byte", d, 8'h3D);
        repeat (200) @(negedge clk);
        cpu_read(1'b0, st);
        chk(st[4] == 1'b0, "R8", "no read started after STOP", st[4], 0);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R7", "bus released after STOP", {scl_oe, sda_oe}, 0);

        // R9 contention on SDA, then R8 clear by data read
        role = 3;
        expect_item(1, 0, 0, "R2");
        expect_item(3, 8'h00, 1'b1, "R9");
        cpu_write(1'b0, 8'h01);
        cpu_write(1'b1, 8'hFF);
        wait_done(st);
        chk(st[6] == 1'b1, "R9", "bus error on jammed SDA", st[6], 1);
        role = 0;
        expect_item(2, 0, 0, "R7");
        cpu_write(1'b0, 8'h02);
        wait_stop(st);
        chk(st[6] == 1'b1, "R9", "bus error held until data access", st[6], 1);
        cpu_read(1'b1, d);
        cpu_read(1'b0, st);
        chk(st[6] == 1'b0, "R8", "bus error cleared by data read", st[6], 0);

        repeat (100) @(negedge clk);
        chk(expq.size() == 0, "R3", "all expected bus events seen", expq.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule